// File: doc/BRIEF.md
# PCIe Lane Bifurcation Strap Resolver

This block settles how a 16-lane PCIe controller is split into root ports. It takes two strap sources: a 2-bit board pin strap and a software strap. The software strap gives a width code and a reversal bit for each 4-lane group. Both are captured on the first clock edge after reset is released. The block merges them group by group, and the narrower split always wins. The result is a set of four candidate root ports, one starting at each 4-lane group. Each candidate carries an enable, a link width, a lane-reversal flag, a root-port number and a PCI function number.

Lane reversal comes only from the software strap. A port takes the reversal bit of the lowest group of the software-defined port that contains it, so a reversed x16 software setting split by the pins into two x8 ports gives two reversed x8 ports. After resolution, an endpoint-width report can narrow an enabled port to x2 or x1. Straps cannot change until the next reset.

Top module: `lane_split_resolver`

## Requirements
- R1: Pin strap and software strap are captured on the first rising clock edge after reset is released. Later changes to either strap input have no effect on any output until the next reset.
- R2: `resolvedValid` is high for exactly one cycle, in the cycle after the second rising edge following reset release. Before that edge all port enables are 0.
- R3: Pin strap decoding, with group g covering lanes 4g+1..4g+4:
  - 2'b00 selects one x16 port.
  - 2'b10 selects two x8 ports.
  - 2'b11 selects an x8 port on groups 0-1 and x4 ports on groups 2 and 3.
- R4: Pin strap 2'b01 is resolved as one x16 port and sets `strapErr`.
- R5: The software width code for group g sits at `swWidth[2g+1:2g]`, with 0=x4, 1=x8 and 2=x16. For each group the final size is the smaller of the pin size and the software size, so matching straps keep their common split.
- R6: The reversal flag of a resolved port is `swRev` at the lowest group of the software port containing it. The pin strap never sets reversal. Reversal bits of groups that are not a software-port start are ignored.
- R7: The software strap is illegal when any of the following holds: a code of 3, a port that is not aligned to its size, or groups of one port with differing codes. An illegal software strap is ignored entirely: the pin result is used, all reversal flags are 0 and `strapErr` is set.
- R8: A candidate port p is enabled only if its group starts a resolved port. `portNum` field p (`portNum[5p+4:5p]`) holds the lowest lane number 4p+1 when enabled and 0 otherwise.
- R9: `portFunc` field p (`portFunc[2p+1:2p]`) is 0 for the lowest enabled port and p for every other enabled port. It is 0 for disabled ports.
- R10: `portWidth` field p (`portWidth[3p+2:3p]`) is log2 of the lane count (0=x1 .. 4=x16), and 0 for disabled ports. The width of an endpoint report applies in the cycle after `epStb[p]` is sampled, as follows:
  - A report narrower than the current width of an enabled port narrows that port.
  - A report that is wider or equal, or that targets a disabled port, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinStrap | input | 2 | Board pin strap |
| swWidth | input | 8 | Software width code per 4-lane group |
| swRev | input | 4 | Software reversal bit per group |
| epStb | input | 4 | Endpoint width report strobe per port |
| epWidth | input | 12 | Reported endpoint width per port, log2 lanes |
| portEn | output | 4 | Root port enable |
| portWidth | output | 12 | Link width per port, log2 lanes |
| portRev | output | 4 | Lane reversal per port |
| portNum | output | 20 | Root port number (lowest lane) per port |
| portFunc | output | 8 | PCI function number per port |
| strapErr | output | 1 | Pin code 01 or illegal software strap |
| resolvedValid | output | 1 | One-cycle pulse after resolution |

## Verification
A wrong merged group size appears at once in the enable pattern and in the port numbers and widths, in the same cycle that `resolvedValid` pulses. A wrongly chosen reversal base shows up as a flipped `portRev` bit at that same moment. A capture register that keeps listening to the straps changes the outputs within a cycle or two of a strap change after resolution. A bad endpoint-width clamp shows in `portWidth` on the cycle after the report strobe.

// File: rtl/lane_split_pkg.sv
package lane_split_pkg;
  localparam int LANES     = 16;
  localparam int GRP_LANES = 4;
  localparam int NGRP      = LANES / GRP_LANES;
  localparam int MAXSZ     = $clog2(NGRP);
  localparam int SZW       = $clog2(MAXSZ + 1) + 1;
  localparam int GLOG      = $clog2(GRP_LANES);
  localparam int WLW       = $clog2($clog2(LANES) + 1);
  localparam int FNW       = $clog2(NGRP);
  localparam int PNW       = $clog2(LANES + 1);
  localparam int SWC       = 2;

  typedef struct packed {
    logic latch;
    logic commit;
    logic epAllow;
  } ctrlStrobe_t;
endpackage

// File: rtl/lane_split_ctrl.sv
module lane_split_ctrl
  import lane_split_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  output ctrlStrobe_t ctrl,
  output logic        resolvedValid
);
  typedef enum logic [1:0] {S_LATCH, S_MERGE, S_PULSE, S_HOLD} state_t;
  state_t state, stateNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_LATCH;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctrl = '0;
    unique case (state)
      S_LATCH: begin ctrl.latch = 1'b1; stateNext = S_MERGE; end
      S_MERGE: begin ctrl.commit = 1'b1; stateNext = S_PULSE; end
      S_PULSE: begin ctrl.epAllow = 1'b1; stateNext = S_HOLD; end
      default: begin ctrl.epAllow = 1'b1; stateNext = S_HOLD; end
    endcase
  end

  assign resolvedValid = (state == S_PULSE);
endmodule

// File: rtl/lane_split_dp.sv
module lane_split_dp
  import lane_split_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  ctrlStrobe_t           ctrl,
  input  logic [1:0]            pinStrap,
  input  logic [NGRP*SWC-1:0]   swWidth,
  input  logic [NGRP-1:0]       swRev,
  input  logic [NGRP-1:0]       epStb,
  input  logic [NGRP*WLW-1:0]   epWidth,
  output logic [NGRP-1:0]       portEn,
  output logic [NGRP*WLW-1:0]   portWidth,
  output logic [NGRP-1:0]       portRev,
  output logic [NGRP*PNW-1:0]   portNum,
  output logic [NGRP*FNW-1:0]   portFunc,
  output logic                  strapErr
);
  logic [1:0]               pinQ;
  logic [NGRP*SWC-1:0]      swQ;
  logic [NGRP-1:0]          revQ;
  logic [NGRP-1:0][SZW-1:0] cfgSz;
  logic [NGRP-1:0]          cfgRev;
  logic                     cfgDone;
  logic                     errQ;
  logic [NGRP-1:0][WLW-1:0] epCap;

  logic [NGRP-1:0][SZW-1:0] pinSz, swSz, mSz;
  logic [NGRP-1:0]          mRev;
  logic                     pinErr, swOk;
  logic [NGRP-1:0]          enC;

  // strap capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinQ <= '0; swQ <= '0; revQ <= '0;
    end else if (ctrl.latch) begin
      pinQ <= pinStrap; swQ <= swWidth; revQ <= swRev;
    end
  end

  // pin decode
  always_comb begin
    pinErr = 1'b0;
    for (int g = 0; g < NGRP; g++) begin
      unique case (pinQ)
        2'b00: pinSz[g] = SZW'(MAXSZ);
        2'b10: pinSz[g] = SZW'(MAXSZ - 1);
        2'b11: pinSz[g] = (g < NGRP / 2) ? SZW'(MAXSZ - 1) : SZW'(MAXSZ - 2);
        default: begin pinSz[g] = SZW'(MAXSZ); pinErr = 1'b1; end
      endcase
    end
  end

  // software decode and legality
  always_comb begin
    swOk = 1'b1;
    for (int g = 0; g < NGRP; g++) begin
      swSz[g] = SZW'(swQ[g*SWC +: SWC]);
    end
    for (int g = 0; g < NGRP; g++) begin
      if (int'(swSz[g]) > MAXSZ) swOk = 1'b0;
      for (int k = 0; k < MAXSZ; k++) begin
        if ((k < int'(swSz[g])) && (swSz[g ^ (1 << k)] != swSz[g])) swOk = 1'b0;
      end
    end
  end

  // merge
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      int base;
      base = g & ~((1 << int'(swSz[g])) - 1);
      if (base < 0 || base >= NGRP) base = 0;
      mSz[g]  = (swOk && swSz[g] < pinSz[g]) ? swSz[g] : pinSz[g];
      mRev[g] = swOk ? revQ[base] : 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgSz <= '0; cfgRev <= '0; cfgDone <= 1'b0; errQ <= 1'b0;
    end else if (ctrl.commit) begin
      cfgSz <= mSz; cfgRev <= mRev; cfgDone <= 1'b1; errQ <= pinErr | ~swOk;
    end
  end

  // port enables from alignment of resolved sizes
  always_comb begin
    for (int g = 0; g < NGRP; g++) begin
      enC[g] = cfgDone && ((g & ((1 << int'(cfgSz[g])) - 1)) == 0);
    end
  end

  // endpoint width clamp
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int g = 0; g < NGRP; g++) epCap[g] <= WLW'($clog2(LANES));
    end else if (ctrl.epAllow) begin
      for (int g = 0; g < NGRP; g++) begin
        if (epStb[g] && enC[g] && (epWidth[g*WLW +: WLW] < epCap[g]))
          epCap[g] <= epWidth[g*WLW +: WLW];
      end
    end
  end

  // per-port outputs
  generate
    for (genvar p = 0; p < NGRP; p++) begin : g_port
      logic [WLW-1:0] cfgW;
      assign cfgW = WLW'(cfgSz[p]) + WLW'(GLOG);
      assign portEn[p]  = enC[p];
      assign portRev[p] = enC[p] & cfgRev[p];
      assign portWidth[p*WLW +: WLW] = !enC[p] ? '0 :
                                       (epCap[p] < cfgW) ? epCap[p] : cfgW;
      assign portNum[p*PNW +: PNW]   = enC[p] ? PNW'(p * GRP_LANES + 1) : '0;
    end
  endgenerate

  always_comb begin
    logic found;
    found = 1'b0;
    portFunc = '0;
    for (int p = 0; p < NGRP; p++) begin
      if (enC[p]) begin
        portFunc[p*FNW +: FNW] = found ? FNW'(p) : '0;
        found = 1'b1;
      end
    end
  end

  assign strapErr = errQ;
endmodule

// File: rtl/lane_split_resolver.sv
module lane_split_resolver
  import lane_split_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [1:0]           pinStrap,
  input  logic [NGRP*SWC-1:0]  swWidth,
  input  logic [NGRP-1:0]      swRev,
  input  logic [NGRP-1:0]      epStb,
  input  logic [NGRP*WLW-1:0]  epWidth,
  output logic [NGRP-1:0]      portEn,
  output logic [NGRP*WLW-1:0]  portWidth,
  output logic [NGRP-1:0]      portRev,
  output logic [NGRP*PNW-1:0]  portNum,
  output logic [NGRP*FNW-1:0]  portFunc,
  output logic                 strapErr,
  output logic                 resolvedValid
);
  ctrlStrobe_t ctrl;

  lane_split_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .resolvedValid(resolvedValid)
  );

  lane_split_dp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .pinStrap(pinStrap), .swWidth(swWidth), .swRev(swRev),
    .epStb(epStb), .epWidth(epWidth),
    .portEn(portEn), .portWidth(portWidth), .portRev(portRev),
    .portNum(portNum), .portFunc(portFunc), .strapErr(strapErr)
  );
endmodule

// File: rtl/lane_split_chk.sv
module lane_split_chk
  import lane_split_pkg::*;
(
  input logic                 clk,
  input logic                 rstN,
  input logic [NGRP-1:0]      portEn,
  input logic [NGRP*WLW-1:0]  portWidth,
  input logic [NGRP-1:0]      portRev,
  input logic [NGRP*PNW-1:0]  portNum,
  input logic [NGRP*FNW-1:0]  portFunc,
  input logic                 strapErr,
  input logic                 resolvedValid
);
  logic seen;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) seen <= 1'b0;
    else if (resolvedValid) seen <= 1'b1;
  end

  // R2
  valid_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    resolvedValid |=> !resolvedValid);

  // R2
  valid_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> !resolvedValid);

  // R1
  strap_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    seen |-> ($stable(portEn) && $stable(portRev) && $stable(strapErr) && $stable(portNum)));

  // R8
  first_port_chk: assert property (@(posedge clk) disable iff (!rstN)
    resolvedValid |-> portEn[0]);

  // R9
  first_func_chk: assert property (@(posedge clk) disable iff (!rstN)
    resolvedValid |-> (portFunc[FNW-1:0] == '0));

  generate
    for (genvar p = 0; p < NGRP; p++) begin : g_chk
      // R10
      width_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
        seen |-> (portWidth[p*WLW +: WLW] <= $past(portWidth[p*WLW +: WLW])));
      // R6
      rev_off_chk: assert property (@(posedge clk) disable iff (!rstN)
        !portEn[p] |-> !portRev[p]);
    end
  endgenerate
endmodule

bind lane_split_resolver lane_split_chk u_chk (
  .clk(clk), .rstN(rstN), .portEn(portEn), .portWidth(portWidth),
  .portRev(portRev), .portNum(portNum), .portFunc(portFunc),
  .strapErr(strapErr), .resolvedValid(resolvedValid)
);

// File: tb/sim_lane_split_resolver.sv
module sim_lane_split_resolver;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  pinStrap = 2'b00;
  logic [7:0]  swWidth = 8'h00;
  logic [3:0]  swRev = 4'h0;
  logic [3:0]  epStb = 4'h0;
  logic [11:0] epWidth = 12'h0;
  logic [3:0]  portEn;
  logic [11:0] portWidth;
  logic [3:0]  portRev;
  logic [19:0] portNum;
  logic [7:0]  portFunc;
  logic        strapErr;
  logic        resolvedValid;

  int nChk = 0;
  int nBad = 0;
  bit done = 1'b0;

  lane_split_resolver u0 (
    .clk(clk), .rstN(rstN), .pinStrap(pinStrap), .swWidth(swWidth),
    .swRev(swRev), .epStb(epStb), .epWidth(epWidth), .portEn(portEn),
    .portWidth(portWidth), .portRev(portRev), .portNum(portNum),
    .portFunc(portFunc), .strapErr(strapErr), .resolvedValid(resolvedValid)
  );

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic startUp(input logic [1:0] pin, input logic [7:0] sw, input logic [3:0] rv);
    rstN = 1'b0; epStb = '0; epWidth = '0;
    pinStrap = pin; swWidth = sw; swRev = rv;
    repeat (2) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R2 valid low after capture", 32'(resolvedValid), 0);
    chk("R2 enables off before resolve", 32'(portEn), 0);
    @(posedge clk); @(negedge clk);
    chk("R2 valid pulse", 32'(resolvedValid), 1);
  endtask

  task automatic endPulse();
    @(posedge clk); @(negedge clk);
    chk("R2 valid drops", 32'(resolvedValid), 0);
  endtask

  task automatic expectCfg(input string tag, input logic [3:0] en, input logic [11:0] w,
                           input logic [3:0] rv, input logic [19:0] num,
                           input logic [7:0] fn, input logic err);
    chk({tag, " en"}, 32'(portEn), 32'(en));
    chk({tag, " width"}, 32'(portWidth), 32'(w));
    chk({tag, " rev"}, 32'(portRev), 32'(rv));
    chk({tag, " num"}, 32'(portNum), 32'(num));
    chk({tag, " func"}, 32'(portFunc), 32'(fn));
    chk({tag, " err"}, 32'(strapErr), 32'(err));
  endtask

  task automatic tSingleX16();
    startUp(2'b00, 8'hAA, 4'h0);
    expectCfg("R3 pin00", 4'b0001, 12'h004, 4'b0000, 20'h00001, 8'h00, 1'b0);
    endPulse();
  endtask

  task automatic tPinSplitWins();
    startUp(2'b10, 8'hAA, 4'h0);
    expectCfg("R5 pin x8 vs sw x16", 4'b0101, 12'h0C3, 4'b0000, 20'h02401, 8'h20, 1'b0);
    endPulse();
  endtask

  task automatic tRevPropagate();
    startUp(2'b10, 8'hAA, 4'b0001);
    expectCfg("R6 reversed x16 split", 4'b0101, 12'h0C3, 4'b0101, 20'h02401, 8'h20, 1'b0);
    endPulse();
  endtask

  task automatic tSwSplitWins();
    startUp(2'b00, 8'h55, 4'h0);
    expectCfg("R5 sw x8 vs pin x16", 4'b0101, 12'h0C3, 4'b0000, 20'h02401, 8'h20, 1'b0);
    endPulse();
  endtask

  task automatic tThreeWay();
    startUp(2'b11, 8'h55, 4'b0101);
    expectCfg("R3 R8 R9 pin11", 4'b1101, 12'h483, 4'b1101, 20'h6A401, 8'hE0, 1'b0);
    endPulse();
  endtask

  task automatic tEndpoint();
    @(negedge clk); epStb = 4'b0001; epWidth = 12'h001;
    @(posedge clk); @(negedge clk); epStb = '0;
    chk("R10 narrow port0 to x2", 32'(portWidth), 32'h481);
    epStb = 4'b0100; epWidth = 12'h0C0;
    @(posedge clk); @(negedge clk); epStb = '0;
    chk("R10 wider report ignored", 32'(portWidth), 32'h481);
    epStb = 4'b0010; epWidth = 12'h000;
    @(posedge clk); @(negedge clk); epStb = '0;
    chk("R10 disabled port width", 32'(portWidth), 32'h481);
    chk("R10 disabled port stays off", 32'(portEn), 32'b1101);
    epStb = 4'b0100; epWidth = 12'h000;
    @(posedge clk); @(negedge clk); epStb = '0;
    chk("R10 narrow port2 to x1", 32'(portWidth), 32'h401);
  endtask

  task automatic tPinReserved();
    startUp(2'b01, 8'hAA, 4'h0);
    expectCfg("R4 pin01", 4'b0001, 12'h004, 4'b0000, 20'h00001, 8'h00, 1'b1);
    endPulse();
  endtask

  task automatic tSwIllegal();
    startUp(2'b10, 8'h75, 4'hF);
    expectCfg("R7 code3", 4'b0101, 12'h0C3, 4'b0000, 20'h02401, 8'h20, 1'b1);
    endPulse();
    startUp(2'b00, 8'h14, 4'h0);
    expectCfg("R7 mixed codes", 4'b0001, 12'h004, 4'b0000, 20'h00001, 8'h00, 1'b1);
    endPulse();
  endtask

  task automatic tRevBaseOnly();
    startUp(2'b00, 8'hAA, 4'b1110);
    expectCfg("R6 non-base rev ignored", 4'b0001, 12'h004, 4'b0000, 20'h00001, 8'h00, 1'b0);
    endPulse();
  endtask

  task automatic tAllX4AndHold();
    startUp(2'b00, 8'h00, 4'b1010);
    expectCfg("R8 R9 all x4", 4'b1111, 12'h492, 4'b1010, 20'h6A4A1, 8'hE4, 1'b0);
    endPulse();
    @(negedge clk); pinStrap = 2'b01; swWidth = 8'hAA; swRev = 4'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    expectCfg("R1 straps held", 4'b1111, 12'h492, 4'b1010, 20'h6A4A1, 8'hE4, 1'b0);
    chk("R1 no second pulse", 32'(resolvedValid), 0);
  endtask

  initial begin
    tSingleX16();
    tPinSplitWins();
    tRevPropagate();
    tSwSplitWins();
    tThreeWay();
    tEndpoint();
    tPinReserved();
    tSwIllegal();
    tRevBaseOnly();
    tAllX4AndHold();
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nBad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule